// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register File

This block is a single-channel SPI master that moves one 8-bit word per transfer. Software starts each transfer. It is driven through a small register file of 8-bit registers on a byte-addressed read/write bus. The file holds the configuration, the outgoing byte, the received byte, a start control, a status byte and a clock divisor.

The serial clock is derived from the bus clock. Its period is 4×(divisor+1) bus cycles. Software sets the idle level of the clock, the edge on which data is sampled and the bit order. An internal loopback path can replace the external serial input. When a byte has been shifted, the received byte is latched and a data-ready flag is set. The flag doubles as the interrupt. Chip selects are generated outside this block.

The register bus has no back-pressure: the block accepts a request in every cycle in which `bus_valid` is high. A read returns its data one cycle later with `rd_valid` high for that one cycle. The requester must take the data in that cycle, because the response cannot be stalled.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads zero, status is 0x00, and `sck`, `mosi` and `irq` are low.
- R2: Register offsets are: 0 mode, 1 receive byte, 2 transmit byte, 3 control, 4 status, 6 divisor. Mode, transmit byte and divisor read back what was written. Offsets 3, 5 and 7 read zero. Read data appears on `rd_data` with `rd_valid` high in the cycle after the request is accepted.
- R3: Writing control with bit 0x01 set starts a transfer, provided the port is enabled and idle. The transfer shifts exactly 8 bits of the transmit byte out on `mosi`. Status bit 0x02 (busy) is set while the transfer runs.
- R4: With divisor value D, the first `sck` edge comes 2×(D+1) bus cycles after the start write is accepted. Leading edges are then 4×(D+1) cycles apart.
- R5: Mode bit 0x02 makes `sck` idle high; otherwise it idles low. With mode bit 0x10 set, both sides sample on the leading edge and change data on the trailing edge (SPI mode 0 or 2). With it clear, data changes on the leading edge and is sampled on the trailing edge (SPI mode 1 or 3).
- R6: Mode bit 0x04 selects least-significant-bit-first shifting in both directions. When it is clear, the most significant bit goes first.
- R7: When the last bit has been shifted, busy clears in the same cycle. In that cycle the received byte is loaded into offset 1, and status bit 0x01 and `irq` are set.
- R8: Reading offset 1 clears the data-ready flag and `irq`. Accepting a new start also clears them.
- R9: With mode bit 0x08 (enable) clear, `sck` stays at its idle level, `mosi` stays low and start writes are ignored.
- R10: With mode bit 0x01 set, the receive side takes the outgoing bit internally and ignores `miso`.
- R11: A start written while a transfer is running is ignored. The running byte completes unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request present (always accepted) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after the read |
| rd_data | output | 8 | Read response data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Received byte ready |

## Verification
Transfers are swept over all four clock-polarity/phase combinations, both bit orders, two divisor values and loopback on and off. A bench-side serial slave answers each transfer with a different byte. Because the slave drives a byte unrelated to the one sent, a swapped edge, a wrong bit order or a leaking `miso` path shows up as a mismatch in one direction or the other. The edge times are measured against the divisor to separate a correct prescaler from one that is off by a factor or by one. Separate sequences start a transfer with the port disabled, restart a running transfer, and read the received byte to clear the flag. These sequences tell ignored requests apart from accepted ones.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_RXB  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_TXB  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd6;

  // configuration view of mode[4:0], field order fixed by software
  typedef struct packed {
    logic lead_sample;
    logic enable;
    logic lsb_first;
    logic clk_inv;
    logic loopback;
  } mode_cfg_t;

  localparam int CFG_W = $bits(mode_cfg_t);
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // half period = 2*(div+1) bus cycles
  assign limit = {div, 1'b1};
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              lead,
  input  logic              lsbf,
  input  logic              loop,
  input  logic              miso,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck_act,
  output logic              mosi_bit
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic              busy_q, act_q;
  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt;
  logic              step, leading, sample, shift, din;

  assign step     = busy_q && tick;
  assign leading  = ~edge_q[0];
  assign mosi_bit = lsbf ? tx_sh[0] : tx_sh[DATA_W-1];
  assign din      = loop ? mosi_bit : miso;
  assign sample   = step && (lead ? leading : ~leading);
  assign shift    = step && (lead ? (~leading && edge_q != LAST)
                                  : (leading && edge_q != '0));

  always_comb begin
    rx_nxt = rx_sh;
    if (sample)
      rx_nxt = lsbf ? {din, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], din};
  end

  assign done    = step && (edge_q == LAST);
  assign rx_byte = rx_nxt;
  assign busy    = busy_q;
  assign sck_act = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      act_q  <= 1'b0;
      edge_q <= '0;
      tx_sh  <= tx_byte;
    end else if (step) begin
      act_q  <= ~act_q;
      edge_q <= edge_q + 1'b1;
      rx_sh  <= rx_nxt;
      if (shift) tx_sh <= lsbf ? (tx_sh >> 1) : (tx_sh << 1);
      if (done)  busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic [REG_W-1:0] mode_q, txb_q, rxb_q;
  logic [DIV_W-1:0] div_q;
  logic             ready_q;
  mode_cfg_t        cfg;

  logic wr, rd, start_go;
  logic eng_busy, eng_done, eng_act, eng_bit, tick;
  logic [REG_W-1:0] eng_rx;

  assign cfg      = mode_cfg_t'(mode_q[CFG_W-1:0]);
  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign start_go = wr && bus_addr == OFS_CTRL && bus_wdata[0]
                    && cfg.enable && !eng_busy;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div_q), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(REG_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_go), .tx_byte(txb_q),
    .lead(cfg.lead_sample), .lsbf(cfg.lsb_first), .loop(cfg.loopback),
    .miso(miso), .tick(tick), .busy(eng_busy), .done(eng_done),
    .rx_byte(eng_rx), .sck_act(eng_act), .mosi_bit(eng_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      txb_q  <= '0;
      div_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_MODE: mode_q <= bus_wdata;
        OFS_TXB:  txb_q  <= bus_wdata;
        OFS_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q   <= '0;
      ready_q <= 1'b0;
    end else if (eng_done) begin
      rxb_q   <= eng_rx;
      ready_q <= 1'b1;
    end else if (start_go || (rd && bus_addr == OFS_RXB)) begin
      ready_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        case (bus_addr)
          OFS_MODE: rd_data <= mode_q;
          OFS_RXB:  rd_data <= rxb_q;
          OFS_TXB:  rd_data <= txb_q;
          OFS_STAT: rd_data <= {{(REG_W-2){1'b0}}, eng_busy, ready_q};
          OFS_DIV:  rd_data <= REG_W'(div_q);
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  assign sck  = cfg.enable ? (cfg.clk_inv ^ eng_act) : cfg.clk_inv;
  assign mosi = cfg.enable && eng_busy && eng_bit;
  assign irq  = ready_q;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              sck,
  input logic              mosi,
  input logic              irq,
  input logic              busy,
  input logic [REG_W-1:0]  mode_q
);
  // R5: between transfers the clock rests at the selected idle level
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == mode_q[1]);

  // R9: a disabled port keeps its data line low
  a_r9_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[3] |-> !mosi);

  // R7: the interrupt is never up while shifting
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  // R7: the end of a transfer raises the interrupt
  a_r7_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R8: reading the receive byte while idle drops the interrupt
  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_RXB && !busy) |=> !irq);

  // R3: an accepted start makes the port busy
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_CTRL && bus_wdata[0]
     && mode_q[3] && !busy) |=> busy);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sck(sck), .mosi(mosi),
  .irq(irq), .busy(eng_busy), .mode_q(mode_q)
);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       rd_valid, sck, mosi, irq;
  logic [7:0] rd_data;
  logic       miso = 1'b0;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  // serial slave model
  bit       armed = 0, s_cpol, s_lead, s_lsb;
  bit [7:0] s_tx, s_rx;
  int       s_idx, s_edges, e0_cyc, e2_cyc;
  logic     mosi_mid;

  always @(negedge clk) mosi_mid = mosi;

  function automatic logic s_bit(int i);
    return s_lsb ? s_tx[i] : s_tx[7-i];
  endfunction

  always @(sck) begin
    if (armed) begin
      automatic bit leading = (sck != s_cpol);
      if (s_edges == 0) e0_cyc = cyc;
      if (s_edges == 2) e2_cyc = cyc;
      s_edges++;
      if (leading == s_lead)
        s_rx = s_lsb ? {mosi_mid, s_rx[7:1]} : {s_rx[6:0], mosi_mid};
      if (s_lead && !leading) begin
        s_idx++;
        if (s_idx < 8) miso = s_bit(s_idx);
      end
      if (!s_lead && leading) begin
        miso = s_bit(s_idx);
        s_idx++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = rd_valid ? rd_data : 8'hxx;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic xfer(int m, bit lsb, int d, bit loop, logic [7:0] tx, logic [7:0] stx);
    logic [7:0] v, exp_rx;
    bit ok;
    int start_cyc;
    bit cpol = m[1];
    bit lead = !m[0];
    bus_wr(3'd0, {3'b000, lead, 1'b1, lsb, cpol, loop});
    bus_wr(3'd6, d[7:0]);
    bus_wr(3'd2, tx);
    s_cpol = cpol; s_lead = lead; s_lsb = lsb; s_tx = stx; s_rx = 0;
    s_idx = 0; s_edges = 0;
    miso = lead ? s_bit(0) : 1'b0;
    armed = 1;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 3'd3; bus_wdata = 8'h01;
    @(posedge clk); #1 start_cyc = cyc;
    @(negedge clk); bus_valid = 0; bus_write = 0;
    bus_rd(3'd4, v);
    chk(v == 8'h02, "R3 busy status", v, 8'h02);
    wait_irq(ok);
    armed = 0;
    chk(ok, "R7 completion irq", ok, 1);
    chk(s_rx == tx, "R3 R5 R6 slave received", s_rx, tx);
    chk(e0_cyc - start_cyc == 2*(d+1), "R4 first edge delay", e0_cyc - start_cyc, 2*(d+1));
    chk(e2_cyc - e0_cyc == 4*(d+1), "R4 clock period", e2_cyc - e0_cyc, 4*(d+1));
    chk(s_edges == 16, "R3 edge count", s_edges, 16);
    bus_rd(3'd4, v);
    chk(v == 8'h01, "R7 ready status", v, 8'h01);
    exp_rx = loop ? tx : stx;
    bus_rd(3'd1, v);
    chk(v == exp_rx, loop ? "R10 loopback receive" : "R5 R6 master receive", v, exp_rx);
    chk(irq == 0, "R8 read clears irq", irq, 0);
    chk(sck == cpol, "R5 idle level", sck, cpol);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit ok;
    int idx = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(sck == 0 && mosi == 0 && irq == 0, "R1 reset pins", {sck, mosi, irq}, 0);
    bus_rd(3'd4, v); chk(v == 0, "R1 reset status", v, 0);
    bus_rd(3'd0, v); chk(v == 0, "R1 reset mode", v, 0);
    bus_rd(3'd6, v); chk(v == 0, "R1 reset divisor", v, 0);
    bus_rd(3'd1, v); chk(v == 0, "R1 reset rx", v, 0);
    // R2
    bus_wr(3'd0, 8'h16); bus_wr(3'd2, 8'hC3); bus_wr(3'd6, 8'h7E);
    bus_rd(3'd0, v); chk(v == 8'h16, "R2 mode readback", v, 8'h16);
    bus_rd(3'd2, v); chk(v == 8'hC3, "R2 tx readback", v, 8'hC3);
    bus_rd(3'd6, v); chk(v == 8'h7E, "R2 divisor readback", v, 8'h7E);
    bus_rd(3'd5, v); chk(v == 0, "R2 gap offset", v, 0);
    bus_rd(3'd7, v); chk(v == 0, "R2 top offset", v, 0);
    bus_rd(3'd3, v); chk(v == 0, "R2 control reads zero", v, 0);
    // R9: disabled, idle high
    bus_wr(3'd0, 8'h12); bus_wr(3'd6, 8'h00);
    bus_wr(3'd3, 8'h01);
    repeat (40) @(negedge clk);
    chk(sck == 1 && mosi == 0, "R9 disabled pins", {sck, mosi}, 2);
    bus_rd(3'd4, v); chk(v == 0, "R9 start ignored", v, 0);
    // sweep
    for (int m = 0; m < 4; m++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int dd = 0; dd < 2; dd++)
          for (int lp = 0; lp < 2; lp++) begin
            logic [7:0] tx = 8'h5A ^ 8'(idx * 37);
            logic [7:0] stx = ~tx ^ 8'(idx * 11 + 1);
            xfer(m, lsb[0], dd * 2, lp[0], tx, stx);
            idx++;
          end
    // R11: restart while busy
    bus_wr(3'd0, 8'h18); bus_wr(3'd6, 8'h03); bus_wr(3'd2, 8'hA5);
    s_cpol = 0; s_lead = 1; s_lsb = 0; s_tx = 8'h0F; s_rx = 0; s_idx = 0; s_edges = 0;
    miso = s_bit(0); armed = 1;
    bus_wr(3'd3, 8'h01);
    repeat (20) @(negedge clk);
    bus_wr(3'd2, 8'h3C);
    bus_wr(3'd3, 8'h01);
    wait_irq(ok);
    armed = 0;
    chk(s_rx == 8'hA5, "R11 running byte kept", s_rx, 8'hA5);
    repeat (200) @(negedge clk);
    bus_rd(3'd4, v); chk(v == 8'h01, "R11 no second transfer", v, 8'h01);
    // R8: new start clears ready
    bus_wr(3'd3, 8'h01);
    bus_rd(3'd4, v); chk(v == 8'h02, "R8 start clears ready", v, 8'h02);
    chk(irq == 0, "R8 irq low after start", irq, 0);
    wait_irq(ok);
    chk(ok, "R7 second completion", ok, 1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule